// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block sits at the head of an in-order pipelined fetch unit. It produces a guess for the next fetch address on every clock. It holds the fetch program counter itself. Each cycle it picks the following address from three sources, in this order of priority:

- a correction from the execute stage,
- a stored branch target, when the table entry for the current PC predicts taken,
- the sequential address PC+4.

The table is indexed by low PC bits. Each entry carries a valid bit, a partial tag, a two-bit saturating direction counter and a full target address.

The table is read through a registered port, so it can map onto block RAM. To still have a prediction ready for the PC that is fetched next, the read address is taken from the next-PC multiplexer before the PC register. The registered read result therefore always belongs to the PC now held. This lets a predicted target that is itself a predicted branch redirect fetch again in the very next cycle.

Resolved branches come back from the execute stage as updates. An update that writes the entry being read in the same cycle is forwarded into the read result.

Top module: `bdp_fetch_predictor`

## Requirements
- R1: While `rst_n` is low on a clock edge, the fetch PC becomes `RESET_PC` and every table entry becomes invalid. In the first cycle after reset, `fetch_pc` equals `RESET_PC`, `pred_taken` is 0 and `pred_next_pc` is `RESET_PC`+4.
- R2: For an entry that was never written since reset, the prediction is not taken and `pred_next_pc` equals `fetch_pc`+4.
- R3: A taken update raises a matching entry's counter by one, saturating at 3. From 3, a single not-taken update leaves the prediction taken. A second not-taken update makes it not taken.
- R4: A not-taken update lowers a matching entry's counter by one, saturating at 0. From 0, a single taken update leaves the prediction not taken. A second taken update makes it taken.
- R5: When the entry for `fetch_pc` is valid, its tag matches and its counter is 2 or 3, `pred_taken` is 1 and `pred_next_pc` is the stored target.
- R6: An update to an entry that is invalid, or whose tag differs, installs the new tag and starts the counter from 1 before applying the outcome. Every update rewrites the stored target.
- R7: If the stored tag differs from `fetch_pc`, the entry predicts not taken and `pred_next_pc` is `fetch_pc`+4. The index is PC bits [IDX_W+1:2]. The tag is the TAG_W bits directly above the index.
- R8: On each clock, `fetch_pc` takes `redir_pc` if `redir_valid` was high, otherwise the previous `pred_next_pc`. A redirect overrides a taken prediction.
- R9: A predicted target that is itself a trained taken branch is followed in the next cycle, with no bubble.
- R10: An update that writes the entry being looked up for the next PC, in the same cycle, is visible in the prediction for that PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| redir_valid | input | 1 | Force the next fetch PC to `redir_pc` |
| redir_pc | input | XLEN | Redirect address |
| upd_valid | input | 1 | Resolved branch update this cycle |
| upd_pc | input | XLEN | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | XLEN | Resolved target address |
| fetch_pc | output | XLEN | PC fetched this cycle |
| pred_next_pc | output | XLEN | Predicted PC for the next cycle |
| pred_taken | output | 1 | Current entry predicts taken |

## Verification
The bench builds the block with its default parameters:

- XLEN 32,
- a 256-entry table indexed by PC bits [9:2],
- a 6-bit tag,
- a reset PC of 0x1000.

With these values, addresses 1 KiB apart share an index but carry different tags. Tag mismatch and reallocation of an entry are therefore reachable with a handful of small addresses. A chain of two trained branches shows back-to-back redirection. A short redirect followed by an update to the next sequential PC lands the same-cycle forwarding case exactly.

// File: rtl/bdp_pkg.sv
`timescale 1ns/1ps
// Shared types for the branch direction predictor.
// Assumes a two-bit counter where the upper bit is the predicted direction.
package bdp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    // Saturating one-step move of a direction counter toward the outcome.
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        logic [1:0] v;
        v = cur;
        if (taken) begin
            if (v != 2'b11) v = v + 2'd1;
        end else begin
            if (v != 2'b00) v = v - 2'd1;
        end
        return ctr_e'(v);
    endfunction

endpackage

// File: rtl/bdp_table.sv
`timescale 1ns/1ps
// Predictor storage. Valid bits, tags and counters are flops with reset;
// targets sit in a plain array without reset. All read data come out
// through one registered port. A write to the index being read in the
// same cycle is forwarded into the registered result. A second,
// combinational view of the write index serves the read-modify-write
// of the counter.
module bdp_table
    import bdp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 8,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  ctr_e             wr_ctr,
    input  logic [XLEN-1:0]  wr_tgt,
    output logic             lk_valid,
    output logic [TAG_W-1:0] lk_tag,
    output ctr_e             lk_ctr,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output ctr_e             rd_ctr,
    output logic [XLEN-1:0]  rd_tgt
);
    localparam int DEPTH = 1 << IDX_W;

    logic             valid_q [DEPTH];
    logic [TAG_W-1:0] tag_q   [DEPTH];
    ctr_e             ctr_q   [DEPTH];
    logic [XLEN-1:0]  tgt_mem [DEPTH];

    logic fwd;
    assign fwd = wr_en && (wr_idx == rd_idx);

    // Current contents of the entry being updated.
    assign lk_valid = valid_q[wr_idx];
    assign lk_tag   = tag_q[wr_idx];
    assign lk_ctr   = ctr_q[wr_idx];

    // Control fields: reset to invalid and weakly not taken, then written by updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                ctr_q[i]   <= CTR_WNT;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
            ctr_q[wr_idx]   <= wr_ctr;
        end
    end

    // Target array: written on every update, no reset.
    always_ff @(posedge clk) begin
        if (wr_en) tgt_mem[wr_idx] <= wr_tgt;
    end

    // Registered read of the control fields, with same-cycle write forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_tag   <= '0;
            rd_ctr   <= CTR_WNT;
        end else if (fwd) begin
            rd_valid <= 1'b1;
            rd_tag   <= wr_tag;
            rd_ctr   <= wr_ctr;
        end else begin
            rd_valid <= valid_q[rd_idx];
            rd_tag   <= tag_q[rd_idx];
            rd_ctr   <= ctr_q[rd_idx];
        end
    end

    // Registered read of the target, with same-cycle write forwarding.
    always_ff @(posedge clk) begin
        rd_tgt <= fwd ? wr_tgt : tgt_mem[rd_idx];
    end

endmodule

// File: rtl/bdp_ctr_update.sv
`timescale 1ns/1ps
// Computes the counter value written back by a resolved branch.
// A matching valid entry steps from its stored value. Any other entry
// is reallocated, starting from weakly not taken before the step.
module bdp_ctr_update
    import bdp_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_taken,
    input  logic             lk_valid,
    input  logic [TAG_W-1:0] lk_tag,
    input  ctr_e             lk_ctr,
    output logic             hit,
    output ctr_e             new_ctr
);
    ctr_e base;

    // Choose the starting value and apply one saturating step.
    always_comb begin
        hit     = lk_valid && (lk_tag == upd_tag);
        base    = hit ? lk_ctr : CTR_WNT;
        new_ctr = ctr_step(base, upd_taken);
    end

endmodule

// File: rtl/bdp_next_pc.sv
`timescale 1ns/1ps
// Turns the registered table read for the current PC into a prediction.
// Selects the next fetch PC from redirect, stored target or PC+4.
// Assumes the read data belong to pc_q, which the caller guarantees by
// addressing the table with this module's next_pc.
module bdp_next_pc
    import bdp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 8,
    parameter int TAG_W = 6
) (
    input  logic [XLEN-1:0]  pc_q,
    input  logic             rd_valid,
    input  logic [TAG_W-1:0] rd_tag,
    input  ctr_e             rd_ctr,
    input  logic [XLEN-1:0]  rd_tgt,
    input  logic             redir_valid,
    input  logic [XLEN-1:0]  redir_pc,
    output logic             pred_taken,
    output logic [XLEN-1:0]  pred_pc,
    output logic [XLEN-1:0]  next_pc
);
    // Direction from tag match and counter, then the three-way address select.
    always_comb begin
        pred_taken = rd_valid && (rd_tag == pc_q[IDX_W+2 +: TAG_W]) && rd_ctr[1];
        pred_pc    = pred_taken ? rd_tgt : (pc_q + XLEN'(4));
        next_pc    = redir_valid ? redir_pc : pred_pc;
    end

endmodule

// File: rtl/bdp_fetch_predictor.sv
`timescale 1ns/1ps
// Fetch-address predictor top. Holds the fetch PC and produces a
// next-PC guess every cycle. Uses a block-RAM-style table read at the
// next-PC address, and a read-modify-write update from the execute stage.
// Assumes TAG_W + IDX_W + 2 < XLEN.
module bdp_fetch_predictor
    import bdp_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              IDX_W    = 8,
    parameter int              TAG_W    = 6,
    parameter logic [XLEN-1:0] RESET_PC = 'h1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redir_valid,
    input  logic [XLEN-1:0] redir_pc,
    input  logic            upd_valid,
    input  logic [XLEN-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [XLEN-1:0] upd_target,
    output logic [XLEN-1:0] fetch_pc,
    output logic [XLEN-1:0] pred_next_pc,
    output logic            pred_taken
);
    localparam int TAG_LO = IDX_W + 2;

    logic [XLEN-1:0]  pc_q;
    logic [XLEN-1:0]  next_pc;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    ctr_e             rd_ctr;
    logic [XLEN-1:0]  rd_tgt;
    logic             lk_valid;
    logic [TAG_W-1:0] lk_tag;
    ctr_e             lk_ctr;
    logic             upd_hit;
    ctr_e             upd_ctr;
    logic [IDX_W-1:0] upd_idx;
    logic [TAG_W-1:0] upd_tag;
    logic             unused_pc_bits;

    assign upd_idx = upd_pc[IDX_W+1:2];
    assign upd_tag = upd_pc[TAG_LO +: TAG_W];
    assign unused_pc_bits = ^{upd_pc[1:0], upd_pc[XLEN-1:TAG_LO+TAG_W],
                              next_pc[1:0], next_pc[XLEN-1:TAG_LO]};

    bdp_table #(.XLEN(XLEN), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (next_pc[IDX_W+1:2]),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_tag   (upd_tag),
        .wr_ctr   (upd_ctr),
        .wr_tgt   (upd_target),
        .lk_valid (lk_valid),
        .lk_tag   (lk_tag),
        .lk_ctr   (lk_ctr),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_ctr   (rd_ctr),
        .rd_tgt   (rd_tgt)
    );

    bdp_ctr_update #(.TAG_W(TAG_W)) u_upd (
        .upd_tag   (upd_tag),
        .upd_taken (upd_taken),
        .lk_valid  (lk_valid),
        .lk_tag    (lk_tag),
        .lk_ctr    (lk_ctr),
        .hit       (upd_hit),
        .new_ctr   (upd_ctr)
    );

    bdp_next_pc #(.XLEN(XLEN), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_sel (
        .pc_q        (pc_q),
        .rd_valid    (rd_valid),
        .rd_tag      (rd_tag),
        .rd_ctr      (rd_ctr),
        .rd_tgt      (rd_tgt),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .pred_taken  (pred_taken),
        .pred_pc     (pred_next_pc),
        .next_pc     (next_pc)
    );

    // Fetch PC register: loads the reset vector, then follows the selected next PC.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= next_pc;
    end

    assign fetch_pc = pc_q;

endmodule

// File: rtl/bdp_checker.sv
`timescale 1ns/1ps
// Temporal checks on the fetch predictor, attached by bind.
// Observes the ports plus the next-PC and update-hit nets of the top.
module bdp_checker #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 'h1000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            redir_valid,
    input logic [XLEN-1:0] redir_pc,
    input logic            upd_valid,
    input logic [XLEN-1:0] upd_pc,
    input logic            upd_taken,
    input logic [XLEN-1:0] upd_target,
    input logic [XLEN-1:0] fetch_pc,
    input logic [XLEN-1:0] pred_next_pc,
    input logic            pred_taken,
    input logic [XLEN-1:0] next_pc,
    input logic            upd_hit
);
    // R1: first cycle out of reset starts at the reset vector, not taken
    a_r1_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fetch_pc == RESET_PC) && !pred_taken);

    // R2 / R7: a not-taken prediction always points at the sequential address
    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == fetch_pc + XLEN'(4));

    // R8: without a redirect the fetch PC follows the prediction
    a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_valid |=> fetch_pc == $past(pred_next_pc));

    // R8: a redirect wins over any prediction
    a_r8_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> fetch_pc == $past(redir_pc));

    // R6 / R10: a taken allocation into the entry being looked up is used at once
    a_r10_forward_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && !upd_hit && (upd_pc == next_pc))
        |=> pred_taken && (pred_next_pc == $past(upd_target)));
endmodule

bind bdp_fetch_predictor bdp_checker #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .redir_valid  (redir_valid),
    .redir_pc     (redir_pc),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target),
    .fetch_pc     (fetch_pc),
    .pred_next_pc (pred_next_pc),
    .pred_taken   (pred_taken),
    .next_pc      (next_pc),
    .upd_hit      (upd_hit)
);

// File: tb/tb_bdp_fetch_predictor.sv
`timescale 1ns/1ps
// Bench: behavioural table model compared against the outputs every cycle,
// plus hand-computed expectations at the requirement corner cases.
module tb_bdp_fetch_predictor;
    localparam logic [31:0] RST_PC = 32'h0000_1000;
    localparam logic [31:0] PA = 32'h0000_1100;   // idx 0x40, tag 4
    localparam logic [31:0] PB = 32'h0000_1400;   // idx 0x00, tag 5
    localparam logic [31:0] PX = 32'h0000_1500;   // idx 0x40, tag 5 (aliases PA)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redir_valid = 1'b0;
    logic [31:0] redir_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic [31:0] fetch_pc;
    logic [31:0] pred_next_pc;
    logic        pred_taken;

    always #2.5 clk = ~clk;

    bdp_fetch_predictor #(.XLEN(32), .IDX_W(8), .TAG_W(6), .RESET_PC(RST_PC)) dut (
        .clk(clk), .rst_n(rst_n),
        .redir_valid(redir_valid), .redir_pc(redir_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target),
        .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc), .pred_taken(pred_taken)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R8";

    // Reference model
    bit          m_valid [256];
    logic [5:0]  m_tag   [256];
    int          m_ctr   [256];
    logic [31:0] m_tgt   [256];
    logic [31:0] m_pc;

    // Stimulus for the next tick
    bit g_rv, g_uv, g_ut;
    logic [31:0] g_rpc, g_upc, g_utg;
    // Hand expectation for the next tick
    bit h_en; string h_req; logic [31:0] h_pc, h_nx; bit h_tk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_now(input string req, input logic [31:0] pc,
                              input bit tk, input logic [31:0] nx);
        h_en = 1; h_req = req; h_pc = pc; h_tk = tk; h_nx = nx;
    endtask

    task automatic redirect(input logic [31:0] pc);
        g_rv = 1; g_rpc = pc;
    endtask

    task automatic update(input logic [31:0] pc, input bit tk, input logic [31:0] tg);
        g_uv = 1; g_upc = pc; g_ut = tk; g_utg = tg;
    endtask

    // Check the current cycle, drive its inputs, advance the model, move to the next cycle.
    task automatic tick();
        int i; int j; int base; bit tk; logic [31:0] nx;
        i  = int'(m_pc[9:2]);
        tk = m_valid[i] && (m_tag[i] == m_pc[15:10]) && (m_ctr[i] >= 2);
        nx = tk ? m_tgt[i] : m_pc + 32'd4;
        chk(cur_req, "fetch_pc", fetch_pc, m_pc);
        chk(cur_req, "pred_taken", {31'd0, pred_taken}, {31'd0, tk});
        chk(cur_req, "pred_next_pc", pred_next_pc, nx);
        if (h_en) begin
            chk(h_req, "fetch_pc(hand)", fetch_pc, h_pc);
            chk(h_req, "pred_taken(hand)", {31'd0, pred_taken}, {31'd0, h_tk});
            chk(h_req, "pred_next_pc(hand)", pred_next_pc, h_nx);
            h_en = 0;
        end
        redir_valid = g_rv; redir_pc = g_rpc;
        upd_valid = g_uv; upd_pc = g_upc; upd_taken = g_ut; upd_target = g_utg;
        m_pc = g_rv ? g_rpc : nx;
        if (g_uv) begin
            j = int'(g_upc[9:2]);
            base = (m_valid[j] && m_tag[j] == g_upc[15:10]) ? m_ctr[j] : 1;
            m_ctr[j]   = g_ut ? ((base < 3) ? base + 1 : 3) : ((base > 0) ? base - 1 : 0);
            m_valid[j] = 1;
            m_tag[j]   = g_upc[15:10];
            m_tgt[j]   = g_utg;
        end
        g_rv = 0; g_uv = 0; g_ut = 0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] rnd_pc();
        return 32'h0000_1000 + (($urandom % 32) << 2) + (($urandom % 2) << 10);
    endfunction

    initial begin
        for (int k = 0; k < 256; k++) begin
            m_valid[k] = 0; m_tag[k] = '0; m_ctr[k] = 1; m_tgt[k] = '0;
        end
        m_pc = RST_PC;
        g_rv = 0; g_uv = 0; g_ut = 0; g_rpc = '0; g_upc = '0; g_utg = '0; h_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1"; expect_now("R1", RST_PC, 0, RST_PC + 4); tick();
        cur_req = "R2"; expect_now("R2", RST_PC + 4, 0, RST_PC + 8);
        update(PA, 1, PB); tick();
        redirect(PA); tick();
        cur_req = "R5"; expect_now("R6", PA, 1, PB); tick();          // alloc 01 -> 10
        cur_req = "R8"; expect_now("R8", PB, 0, PB + 4);
        update(PA, 1, PB); tick();                                    // 11
        cur_req = "R3";
        update(PA, 1, PB); tick();                                    // stays 11
        update(PA, 0, PB); tick();                                    // 10
        redirect(PA); tick();
        expect_now("R3", PA, 1, PB); update(PA, 0, PB); tick();       // 01
        redirect(PA); tick();
        expect_now("R3", PA, 0, PA + 4); tick();
        cur_req = "R4";
        update(PA, 0, PB); tick();                                    // 00
        update(PA, 0, PB); tick();                                    // stays 00
        update(PA, 1, PB); tick();                                    // 01
        redirect(PA); tick();
        expect_now("R4", PA, 0, PA + 4); update(PA, 1, PB); tick();   // 10
        redirect(PA); tick();
        expect_now("R4", PA, 1, PB); tick();
        cur_req = "R7";
        redirect(PX); tick();
        expect_now("R7", PX, 0, PX + 4); tick();
        cur_req = "R9";
        update(PB, 1, 32'h0000_1800); tick();
        redirect(PA); tick();
        expect_now("R9", PA, 1, PB); tick();
        expect_now("R9", PB, 1, 32'h0000_1800); tick();
        expect_now("R9", 32'h0000_1800, 0, 32'h0000_1804); tick();
        cur_req = "R8";
        redirect(PA); tick();
        redirect(32'h0000_1040); tick();
        expect_now("R8", 32'h0000_1040, 0, 32'h0000_1044); tick();
        cur_req = "R10";
        redirect(32'h0000_1204); tick();
        update(32'h0000_1208, 1, 32'h0000_1600); tick();
        expect_now("R10", 32'h0000_1208, 1, 32'h0000_1600); tick();
        cur_req = "R6";
        update(PA, 1, 32'h0000_1700); tick();
        redirect(PA); tick();
        expect_now("R6", PA, 1, 32'h0000_1700); tick();
        update(PX, 0, 32'h0000_1300); tick();                         // realloc tag 5, ctr 00
        redirect(PA); tick();
        expect_now("R7", PA, 0, PA + 4); tick();
        redirect(PX); tick();
        expect_now("R6", PX, 0, PX + 4); tick();

        cur_req = "R9";
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 5 == 0) redirect(rnd_pc());
            if ($urandom % 2 == 0) update(rnd_pc(), 1'($urandom % 3 != 0), rnd_pc());
            tick();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule